// File: doc/BRIEF.md
# Windowed Keyed-Command Watchdog

This block supervises software progress with an 8-bit up counter. The counter advances on one of several prescaled tick lanes, and a field in the control register picks the lane. Software must keep the counter from wrapping by writing a specific byte value to a separate command port. A second byte value switches the watchdog off, but only after the enable bit in the control register has first been written to zero. Any other command byte does nothing.

A malfunction is either a wrap of the counter or a clear that arrives too early while a clear window is selected. The output-select bit decides how a malfunction is reported. It is either a one-cycle non-maskable interrupt pulse or a reset request. The reset request stays asserted until the block's own reset input is applied.

The block is built around a three-state controller:

- **ST_OFF**: stopped, with the counter held at zero.
- **ST_RUN**: counting.
- **ST_TRIP**: a reset request has been raised and is being held.

Transitions:

- `go_run`: ST_OFF to ST_RUN, on a control write with the enable bit at 1.
- `go_off`: ST_RUN to ST_OFF, on an accepted off command.
- `go_trip`: ST_RUN to ST_TRIP, on a malfunction while reset output is selected.
- ST_TRIP leaves only through `rst_n`.

Top module: `wdog_window`

## Requirements
- R1: In ST_RUN the counter advances by one on each cycle where the tick lane selected by control bits [5:4] is high. Pulses on the other lanes have no effect.
- R2: A command write of 8'h4E in ST_RUN clears the counter to 0, and counting resumes from 0 on later ticks.
- R3: A command write of 8'hB1 moves the block to ST_OFF only while control bit 0 (enable) is 0; with enable at 1 the write is ignored. In ST_OFF the counter stays 0, ticks and commands have no effect, and a control write with bit 0 at 1 restarts counting from 0.
- R4: A selected tick while the counter is 255, with no clear command in that cycle, wraps the counter to 0 and counts as a malfunction.
- R5: With control bit 1 (output select) at 0, a malfunction makes `nmi_req` high for exactly the one cycle after the event. No enable or mask gates it.
- R6: With control bit 1 at 1, a malfunction sets `rst_req` from the next cycle and holds it until `rst_n`. While it is held, the counter is frozen and command and control writes are ignored.
- R7: When a clear command and a wrapping tick fall in the same cycle, the clear wins: the counter becomes 0 and no malfunction is reported.
- R8: Control bits [3:2] select the clear window:
  - 00 and 11: a clear is allowed at any count.
  - 01: a clear is allowed only at a count of 128 or more.
  - 10: a clear is allowed only at a count of 192 or more.

  A clear below the allowed count is a malfunction, and it still clears the counter.
- R9: Command bytes other than 8'h4E and 8'hB1 change neither the counter nor the outputs.
- R10: After reset the block is in ST_RUN with enable 1, output select 1, window 00, lane 0, counter 0, and both request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_vec | input | N_TICK | Prescaled tick lanes, one cycle wide each |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control data: [0] enable, [1] output select, [3:2] window, [5:4] lane |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | Held reset request |
| wd_on | output | 1 | High when not in ST_OFF |
| cnt_out | output | CNT_W | Current counter value |

## Verification
The hardest case to reach from the ports is a clear command that lands in exactly the cycle where the selected tick would wrap the counter. Nearly as hard are clears placed precisely one count below and exactly at the window threshold. The stimulus drives the selected lane every cycle from a known zero, so the count is exact at every cycle. Clear commands are then placed on the cycle where the count sits at 255, 127, 128, 191 and 192.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int TSEL_W = 2;

    localparam logic [7:0] KEY_CLEAR = 8'h4E;
    localparam logic [7:0] KEY_OFF   = 8'hB1;

    localparam logic [1:0] WIN_OPEN  = 2'b00;
    localparam logic [1:0] WIN_HALF  = 2'b01;
    localparam logic [1:0] WIN_3Q    = 2'b10;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_STOP  = 2'd2
    } wd_cmd_e;

    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        logic [1:0]        win;
        logic              osel;
        logic              en;
    } wd_ctrl_t;

    localparam int CTRL_W = $bits(wd_ctrl_t);

    localparam wd_ctrl_t CTRL_DEFAULT = '{tsel: '0, win: WIN_OPEN, osel: 1'b1, en: 1'b1};

endpackage

// File: rtl/wdk_cmd_decode.sv
module wdk_cmd_decode
    import wdk_pkg::*;
(
    input  logic       cmd_we,
    input  logic [7:0] cmd_wdata,
    input  logic       running,
    input  logic       en_bit,
    output wd_cmd_e    cmd_kind
);

    always_comb begin
        cmd_kind = CMD_NONE;
        if (cmd_we && running) begin
            if (cmd_wdata == KEY_CLEAR) begin
                cmd_kind = CMD_CLEAR;
            end else if (cmd_wdata == KEY_OFF && !en_bit) begin
                cmd_kind = CMD_STOP;
            end
        end
    end

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int N_TICK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TICK-1:0] tick_vec,
    input  logic [TSEL_W-1:0] tsel,
    input  logic [1:0]        win,
    input  logic              run,
    input  logic              zero,
    input  logic              clr,
    output logic [CNT_W-1:0]  cnt,
    output logic              tick_hit,
    output logic              ovf,
    output logic              early
);

    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] THR_HALF  = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] THR_3Q    = THR_HALF + (THR_HALF >> 1);

    logic gate_ok;

    always_comb begin
        tick_hit = 1'b0;
        for (int i = 0; i < N_TICK; i++) begin
            if (tsel == TSEL_W'(i)) begin
                tick_hit = tick_vec[i];
            end
        end
    end

    always_comb begin
        unique case (win)
            WIN_HALF: gate_ok = (cnt >= THR_HALF);
            WIN_3Q:   gate_ok = (cnt >= THR_3Q);
            default:  gate_ok = 1'b1;
        endcase
    end

    assign early = run && clr && !gate_ok;
    assign ovf   = run && tick_hit && (cnt == CNT_MAX) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (zero) begin
            cnt <= '0;
        end else if (run) begin
            if (clr) begin
                cnt <= '0;
            end else if (tick_hit) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm
    import wdk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  wd_cmd_e    cmd_kind,
    input  logic       fault,
    output wd_ctrl_t   ctrl_q,
    output wd_state_e  state,
    output logic       zero,
    output logic       nmi_req,
    output logic       rst_req,
    output logic       wd_on
);

    wd_state_e state_next;
    wd_ctrl_t  ctrl_new;

    assign ctrl_new = wd_ctrl_t'(ctrl_wdata[CTRL_W-1:0]);

    always_comb begin
        state_next = state;
        unique case (state)
            ST_OFF: begin
                if (ctrl_we && ctrl_new.en) begin
                    state_next = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fault && ctrl_q.osel) begin
                    state_next = ST_TRIP;
                end else if (cmd_kind == CMD_STOP) begin
                    state_next = ST_OFF;
                end
            end
            ST_TRIP: state_next = ST_TRIP;
            default: state_next = ST_TRIP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            ctrl_q <= CTRL_DEFAULT;
        end else begin
            state <= state_next;
            if (ctrl_we && state != ST_TRIP) begin
                ctrl_q <= ctrl_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_req <= 1'b0;
        end else begin
            nmi_req <= (state == ST_RUN) && fault && !ctrl_q.osel;
        end
    end

    assign zero    = (state == ST_OFF) || (state == ST_RUN && state_next == ST_OFF);
    assign rst_req = (state == ST_TRIP);
    assign wd_on   = (state != ST_OFF);

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdk_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int N_TICK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TICK-1:0] tick_vec,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_wdata,
    output logic              nmi_req,
    output logic              rst_req,
    output logic              wd_on,
    output logic [CNT_W-1:0]  cnt_out
);

    wd_ctrl_t  ctrl_q;
    wd_state_e state;
    wd_cmd_e   cmd_kind;
    logic      running;
    logic      zero;
    logic      tick_hit;
    logic      ovf;
    logic      early;
    logic      fault;
    logic      out_sel;

    assign running = (state == ST_RUN);
    assign fault   = ovf || early;
    assign out_sel = ctrl_q.osel;

    wdk_cmd_decode u_dec (
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .running   (running),
        .en_bit    (ctrl_q.en),
        .cmd_kind  (cmd_kind)
    );

    wdk_counter #(
        .CNT_W  (CNT_W),
        .N_TICK (N_TICK)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_vec (tick_vec),
        .tsel     (ctrl_q.tsel),
        .win      (ctrl_q.win),
        .run      (running),
        .zero     (zero),
        .clr      (cmd_kind == CMD_CLEAR),
        .cnt      (cnt_out),
        .tick_hit (tick_hit),
        .ovf      (ovf),
        .early    (early)
    );

    wdk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .cmd_kind   (cmd_kind),
        .fault      (fault),
        .ctrl_q     (ctrl_q),
        .state      (state),
        .zero       (zero),
        .nmi_req    (nmi_req),
        .rst_req    (rst_req),
        .wd_on      (wd_on)
    );

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [7:0]       cmd_wdata,
    input logic             nmi_req,
    input logic             rst_req,
    input logic             wd_on,
    input logic [CNT_W-1:0] cnt_out,
    input logic             tick_hit,
    input logic             out_sel
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_nmi_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    assert_rst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    assert_cnt_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> $stable(cnt_out));

    assert_off_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_on |-> (cnt_out == '0));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && !rst_req) |=>
            (cnt_out == $past(cnt_out) || cnt_out == $past(cnt_out) + 1'b1 || cnt_out == '0));

    assert_wrap_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && !rst_req && cnt_out == TOP && tick_hit && !cmd_we && !out_sel) |=> nmi_req);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && !rst_req && cnt_out == TOP && cmd_we && cmd_wdata == KEY_CLEAR)
            |=> (!nmi_req && !rst_req && cnt_out == '0));

endmodule

bind wdog_window wdk_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .nmi_req   (nmi_req),
    .rst_req   (rst_req),
    .wd_on     (wd_on),
    .cnt_out   (cnt_out),
    .tick_hit  (tick_hit),
    .out_sel   (out_sel)
);

// File: tb/sim_wdog_window.sv
module sim_wdog_window;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tick_vec = '0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic       nmi_req;
    logic       rst_req;
    logic       wd_on;
    logic [7:0] cnt_out;

    int total = 0;
    int bad = 0;
    int mc = 0;
    logic [3:0] lane_v = 4'b0001;

    typedef struct {
        logic       nmi;
        logic       rst;
        logic       on;
        logic [7:0] cnt;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    wdog_window u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_vec   (tick_vec),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .cmd_we     (cmd_we),
        .cmd_wdata  (cmd_wdata),
        .nmi_req    (nmi_req),
        .rst_req    (rst_req),
        .wd_on      (wd_on),
        .cnt_out    (cnt_out)
    );

    task automatic compare(input exp_t e);
        total++;
        if (nmi_req !== e.nmi || rst_req !== e.rst || wd_on !== e.on || cnt_out !== e.cnt) begin
            bad++;
            $display("FAIL %s: got nmi=%b rst=%b on=%b cnt=%0d, expected nmi=%b rst=%b on=%b cnt=%0d",
                     e.tag, nmi_req, rst_req, wd_on, cnt_out, e.nmi, e.rst, e.on, e.cnt);
        end
    endtask

    // monitor: compares the expectation queued before each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                compare(q.pop_front());
            end
        end
    end

    task automatic step(input logic [3:0] tv, input logic kw, input logic [7:0] kd,
                        input logic cw, input logic [7:0] cd,
                        input logic en, input logic er, input logic eo,
                        input logic [7:0] ec, input string tag);
        exp_t e;
        @(negedge clk);
        tick_vec   = tv;
        cmd_we     = kw;
        cmd_wdata  = kd;
        ctrl_we    = cw;
        ctrl_wdata = cd;
        e.nmi = en; e.rst = er; e.on = eo; e.cnt = ec; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick_run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            mc = mc + 1;
            step(lane_v, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'(mc), tag);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_vec = '0; cmd_we = 0; ctrl_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mc = 0;
        #1;
        total++;
        if (nmi_req !== 1'b0 || rst_req !== 1'b0 || wd_on !== 1'b1 || cnt_out !== 8'd0) begin
            bad++;
            $display("FAIL R10 reset state: got nmi=%b rst=%b on=%b cnt=%0d, expected nmi=0 rst=0 on=1 cnt=0",
                     nmi_req, rst_req, wd_on, cnt_out);
        end
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        apply_reset();

        // R1: counting on lane 0, other lanes ignored
        tick_run(10, "R1 count lane0");
        step(4'b0000, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd10, "R1 no tick holds");
        step(4'b1110, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd10, "R1 other lanes ignored");

        // R2: clear key
        step(4'b0000, 1, 8'h4E, 0, 8'h00, 0, 0, 1, 8'd0, "R2 clear to zero");
        mc = 0;
        tick_run(3, "R2 resumes counting");

        // R9: other bytes ignored
        step(4'b0000, 1, 8'h55, 0, 8'h00, 0, 0, 1, 8'd3, "R9 byte 55 ignored");
        step(4'b0000, 1, 8'h00, 0, 8'h00, 0, 0, 1, 8'd3, "R9 byte 00 ignored");
        step(4'b0000, 1, 8'h4F, 0, 8'h00, 0, 0, 1, 8'd3, "R9 byte 4F ignored");

        // R1: lane select field, output select 0
        step(4'b0000, 0, 8'h00, 1, 8'h11, 0, 0, 1, 8'd3, "R1 ctrl write lane1");
        step(4'b0001, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd3, "R1 lane0 now ignored");
        step(4'b0010, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd4, "R1 lane1 counts");
        step(4'b0000, 0, 8'h00, 1, 8'h01, 0, 0, 1, 8'd4, "R1 back to lane0");
        mc = 4;

        // R4, R5: wrap gives one-cycle interrupt
        tick_run(251, "R4 count to top");
        step(4'b0001, 0, 8'h00, 0, 8'h00, 1, 0, 1, 8'd0, "R4 R5 wrap raises nmi");
        step(4'b0000, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd0, "R5 nmi single cycle");
        mc = 0;

        // R7: clear beats wrap in same cycle
        tick_run(255, "R7 count to top");
        step(4'b0001, 1, 8'h4E, 0, 8'h00, 0, 0, 1, 8'd0, "R7 clear wins over wrap");
        step(4'b0000, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd0, "R7 no late event");
        mc = 0;

        // R8: half window
        step(4'b0000, 0, 8'h00, 1, 8'h05, 0, 0, 1, 8'd0, "R8 select half window");
        tick_run(127, "R8 count to 127");
        step(4'b0000, 1, 8'h4E, 0, 8'h00, 1, 0, 1, 8'd0, "R8 clear at 127 is early");
        step(4'b0000, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd0, "R8 early event pulse ends");
        mc = 0;
        tick_run(128, "R8 count to 128");
        step(4'b0000, 1, 8'h4E, 0, 8'h00, 0, 0, 1, 8'd0, "R8 clear at 128 allowed");
        mc = 0;
        // R8: three-quarter window
        step(4'b0000, 0, 8'h00, 1, 8'h09, 0, 0, 1, 8'd0, "R8 select 3/4 window");
        tick_run(191, "R8 count to 191");
        step(4'b0000, 1, 8'h4E, 0, 8'h00, 1, 0, 1, 8'd0, "R8 clear at 191 is early");
        mc = 0;
        tick_run(192, "R8 count to 192");
        step(4'b0000, 1, 8'h4E, 0, 8'h00, 0, 0, 1, 8'd0, "R8 clear at 192 allowed");
        step(4'b0000, 0, 8'h00, 1, 8'h01, 0, 0, 1, 8'd0, "R8 window open again");
        mc = 0;

        // R3: off key needs enable at 0
        tick_run(5, "R3 count");
        step(4'b0000, 1, 8'hB1, 0, 8'h00, 0, 0, 1, 8'd5, "R3 off key ignored with enable 1");
        step(4'b0000, 0, 8'h00, 1, 8'h00, 0, 0, 1, 8'd5, "R3 enable written 0 still runs");
        step(4'b0001, 0, 8'h00, 0, 8'h00, 0, 0, 1, 8'd6, "R3 counting continues");
        step(4'b0000, 1, 8'hB1, 0, 8'h00, 0, 0, 0, 8'd0, "R3 off key accepted");
        step(4'b0001, 0, 8'h00, 0, 8'h00, 0, 0, 0, 8'd0, "R3 ticks ignored when off");
        step(4'b0001, 1, 8'h4E, 0, 8'h00, 0, 0, 0, 8'd0, "R3 commands ignored when off");
        step(4'b0000, 0, 8'h00, 1, 8'h03, 0, 0, 1, 8'd0, "R3 restart from zero");
        mc = 0;
        tick_run(3, "R3 counts after restart");

        // R6: reset request held
        tick_run(252, "R6 count to top");
        step(4'b0001, 0, 8'h00, 0, 8'h00, 0, 1, 1, 8'd0, "R6 wrap raises reset request");
        step(4'b0001, 0, 8'h00, 0, 8'h00, 0, 1, 1, 8'd0, "R6 counter frozen");
        step(4'b0000, 0, 8'h00, 1, 8'h00, 0, 1, 1, 8'd0, "R6 control write ignored");
        step(4'b0000, 1, 8'hB1, 0, 8'h00, 0, 1, 1, 8'd0, "R6 off key ignored");
        step(4'b0001, 1, 8'h4E, 0, 8'h00, 0, 1, 1, 8'd0, "R6 clear ignored, still held");
        @(negedge clk);
        tick_vec = '0; cmd_we = 0; ctrl_we = 0;
        @(negedge clk);

        // R10: reset returns defaults (output select 1, lane 0)
        apply_reset();
        tick_run(2, "R10 lane0 default");

        @(negedge clk);
        tick_vec = '0;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule